// File: doc/BRIEF.md
# Security-banked floating-point control register file

This block holds the floating-point configuration registers of a system control space. Each access carries a security attribute. Most registers keep one copy for the Secure state and one for the Non-secure state, and the attribute picks the copy. The non-secure access control register has only one copy, which only Secure software can see. The context control register mixes banked bits with bits that are shared between the two states.

A Non-secure write to the context control register is split bit by bit. Banked bits go into the Non-secure copy. Some shared bits in the Secure copy may change, but only where a Secure-owned lock bit or an external grant allows it. A static feature flag removes the whole file when no floating-point unit is present. A revision flag limits the context control register to the bits that an older core revision has.

The registers only store what is written. Read data comes back one clock after the read strobe. Writes take effect at the clock edge that samples the strobe.

Top module: `fpctl_regbank`

## Requirements
- R1: After reset, a Secure read of the context control register (offset 0xF34) returns 0xC0000000: bit 30 (lazy-stacking enable) and bit 31 (automatic preservation enable) are set. Every other register copy reads 0.
- R2: While `fp_present` is low, every listed offset reads 0, and writes to those offsets leave all stored state unchanged.
- R3: The coprocessor access register (0xD88) has one copy per security state, picked by `secure`. A write keeps only bits 23:20 and clears all other bits.
- R4: The non-secure access register (0xD8C) has a single copy. A Non-secure read returns 0 and a Non-secure write is ignored. A Secure write keeps only bits 11:10.
- R5: The context address register (0xF38) has one copy per security state. Every write forces bits 2:0 to 0.
- R6: The default status register (0xF3C) has one copy per security state. A write keeps only the bits in mask 0x07C00000.
- R7: A Secure read of 0xF34 returns the whole Secure copy. A Non-secure read returns the Non-secure copy ORed with the Secure copy masked to bits 30, 28 and 8. When `fault_grant` is high, bits 4 and 6 are added to that mask.
- R8: On a Non-secure write to 0xF34, Secure bit 30 follows the written bit only if Secure bit 29 (its lock) is 0. Secure bit 28 follows the written bit only if Secure bit 27 (its lock) is 0.
- R9: On a Non-secure write to 0xF34, Secure bits 4 and 6 follow the written bits only when `fault_grant` is high. Secure bit 8 always follows the written bit.
- R10: On a Non-secure write to 0xF34, the Non-secure copy stores the written value masked to the banked bits 0, 1, 3, 5, 9 and 10. No Secure bit changes other than bits 4, 6, 8, 28 and 30.
- R11: A write to 0xF34 always clears the reserved bits 25:11. When `rev_new` is low, the write also keeps only bits 0, 1, 3, 4, 5, 6, 8, 30 and 31. A Secure write stores the result into the Secure copy unchanged.
- R12: A read of any unlisted offset returns 0 with `rd_miss` high in the following cycle. A read of a listed offset returns `rd_miss` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | AW (12) | Byte offset of the access |
| secure | input | 1 | Access attribute: 1 = Secure, 0 = Non-secure |
| wdata | input | DW (32) | Write data |
| fp_present | input | 1 | Static flag: floating-point unit present |
| rev_new | input | 1 | Static flag: newer architecture revision |
| fault_grant | input | 1 | Grants Non-secure access to the hard-fault and bus-fault ready bits |
| rdata | output | DW (32) | Read data, valid the cycle after `rd_en` |
| rd_miss | output | 1 | Read hit an unlisted offset, valid the cycle after `rd_en` |

## Verification
A write is due at the clock edge that samples `wr_en`. A read issued at the next falling edge therefore sees it. `rdata` and `rd_miss` are due one edge after the read strobe is sampled. The bench raises every strobe on a falling edge and compares the outputs on the next falling edge, which lies half a period after the edge that produced them. The expected value of each read is taken from the bench model when the strobe is raised, so the model and the design see exactly the same writes before that read.

// File: rtl/fpctl_pkg.sv
package fpctl_pkg;
   localparam int NUM_REGS = 5;

   // register offsets (byte), order matches decode index
   localparam logic [11:0] OFF_CPAC = 12'hD88;
   localparam logic [11:0] OFF_NSAC = 12'hD8C;
   localparam logic [11:0] OFF_FCCR = 12'hF34;
   localparam logic [11:0] OFF_FCAR = 12'hF38;
   localparam logic [11:0] OFF_FDSC = 12'hF3C;
   localparam logic [11:0] OFF_TABLE [NUM_REGS] =
      '{OFF_CPAC, OFF_NSAC, OFF_FCCR, OFF_FCAR, OFF_FDSC};

   localparam int IX_CPAC = 0;
   localparam int IX_NSAC = 1;
   localparam int IX_FCCR = 2;
   localparam int IX_FCAR = 3;
   localparam int IX_FDSC = 4;

   // write-keep masks of the plain registers
   localparam logic [31:0] CPAC_KEEP = 32'h00F0_0000;
   localparam logic [31:0] NSAC_KEEP = 32'h0000_0C00;
   localparam logic [31:0] FCAR_KEEP = 32'hFFFF_FFF8;
   localparam logic [31:0] FDSC_KEEP = 32'h07C0_0000;

   // context control bit positions used by the split-write logic
   localparam int B_HFRD   = 4;
   localparam int B_BFRD   = 6;
   localparam int B_MONRD  = 8;
   localparam int B_CLRLCK = 27;
   localparam int B_CLRRET = 28;
   localparam int B_LSPLCK = 29;
   localparam int B_LSPEN  = 30;

   localparam logic [31:0] CCR_DEFINED  = 32'hFC00_07FF;
   localparam logic [31:0] CCR_OLDREV   = 32'hC000_017B;
   localparam logic [31:0] CCR_BANKED   = 32'h0000_062B;
   localparam logic [31:0] CCR_RESET    = 32'hC000_0000;
   localparam logic [31:0] CCR_NS_TOUCH = 32'h5000_0150;
endpackage

// File: rtl/fpctl_bank.sv
module fpctl_bank #(
   parameter int          DW    = 32,
   parameter int          NCOPY = 2,
   parameter logic [DW-1:0] WMASK = '1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic          sel,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] q [NCOPY];

   initial begin
      assert (NCOPY == 1 || NCOPY == 2) else $error("fpctl_bank: NCOPY must be 1 or 2");
   end

   for (genvar c = 0; c < NCOPY; c++) begin : g_copy
      localparam logic CB = (c != 0);
      logic hit;
      assign hit = (NCOPY == 1) || (sel == CB);
      always_ff @(posedge clk) begin
         if (!rst_n)
            q[c] <= '0;
         else if (we && hit)
            q[c] <= wdata & WMASK;
      end
   end

   if (NCOPY == 2) begin : g_two
      assign rdata = sel ? q[1] : q[0];

      // R3 R5 R6: a write to one security copy leaves the other copy alone
      other_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (we && sel) |=> $stable(q[0]));
   end else begin : g_one
      logic unused_sel;
      assign unused_sel = sel;
      assign rdata = q[0];
   end
endmodule

// File: rtl/fpctl_ccr.sv
module fpctl_ccr
   import fpctl_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic          secure,
   input  logic          rev_new,
   input  logic          fault_grant,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   logic [31:0] s_q, ns_q, v, s_nx, ns_view;

   initial begin
      assert (DW == 32) else $error("fpctl_ccr: DW must be 32");
   end

   always_comb begin
      v = wdata & CCR_DEFINED;
      if (!rev_new) v = v & CCR_OLDREV;
      s_nx = s_q;
      if (secure) begin
         s_nx = v;
      end else begin
         if (!s_q[B_LSPLCK]) s_nx[B_LSPEN]  = v[B_LSPEN];
         if (!s_q[B_CLRLCK]) s_nx[B_CLRRET] = v[B_CLRRET];
         if (fault_grant) begin
            s_nx[B_HFRD] = v[B_HFRD];
            s_nx[B_BFRD] = v[B_BFRD];
         end
         s_nx[B_MONRD] = v[B_MONRD];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s_q  <= CCR_RESET;
         ns_q <= '0;
      end else if (we) begin
         s_q <= s_nx;
         if (!secure) ns_q <= v & CCR_BANKED;
      end
   end

   always_comb begin
      ns_view = '0;
      ns_view[B_LSPEN]  = 1'b1;
      ns_view[B_CLRRET] = 1'b1;
      ns_view[B_MONRD]  = 1'b1;
      ns_view[B_HFRD]   = fault_grant;
      ns_view[B_BFRD]   = fault_grant;
      rdata = secure ? s_q : ((s_q & ns_view) | ns_q);
   end

   // R8
   lsp_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !secure && s_q[B_LSPLCK]) |=> $stable(s_q[B_LSPEN]));

   // R10
   ns_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !secure) |=> (((s_q ^ $past(s_q)) & ~CCR_NS_TOUCH) == 32'h0));

   // R11
   oldrev_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && secure && !rev_new) |=> ((s_q & ~CCR_OLDREV) == 32'h0));
endmodule

// File: rtl/fpctl_regbank.sv
module fpctl_regbank
   import fpctl_pkg::*;
#(
   parameter int DW = 32,
   parameter int AW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_en,
   input  logic          wr_en,
   input  logic [AW-1:0] addr,
   input  logic          secure,
   input  logic [DW-1:0] wdata,
   input  logic          fp_present,
   input  logic          rev_new,
   input  logic          fault_grant,
   output logic [DW-1:0] rdata,
   output logic          rd_miss
);
   localparam int NR = NUM_REGS;

   initial begin
      assert (DW == 32) else $error("fpctl_regbank: DW must be 32");
      assert (AW >= 12) else $error("fpctl_regbank: AW must cover 12-bit offsets");
   end

   logic [NR-1:0] hit, wsel;
   logic          listed;

   for (genvar i = 0; i < NR; i++) begin : g_dec
      assign hit[i]  = (addr == AW'(OFF_TABLE[i]));
      assign wsel[i] = wr_en && fp_present && hit[i];
   end
   assign listed = |hit;

   logic [DW-1:0] cpac_q, nsac_q, fcar_q, fdsc_q, fccr_rd, rd_mux;

   fpctl_bank #(.DW(DW), .NCOPY(2), .WMASK(CPAC_KEEP)) u_cpac (
      .clk(clk), .rst_n(rst_n), .we(wsel[IX_CPAC]), .sel(secure),
      .wdata(wdata), .rdata(cpac_q));

   fpctl_bank #(.DW(DW), .NCOPY(1), .WMASK(NSAC_KEEP)) u_nsac (
      .clk(clk), .rst_n(rst_n), .we(wsel[IX_NSAC] && secure), .sel(secure),
      .wdata(wdata), .rdata(nsac_q));

   fpctl_bank #(.DW(DW), .NCOPY(2), .WMASK(FCAR_KEEP)) u_fcar (
      .clk(clk), .rst_n(rst_n), .we(wsel[IX_FCAR]), .sel(secure),
      .wdata(wdata), .rdata(fcar_q));

   fpctl_bank #(.DW(DW), .NCOPY(2), .WMASK(FDSC_KEEP)) u_fdsc (
      .clk(clk), .rst_n(rst_n), .we(wsel[IX_FDSC]), .sel(secure),
      .wdata(wdata), .rdata(fdsc_q));

   fpctl_ccr #(.DW(DW)) u_fccr (
      .clk(clk), .rst_n(rst_n), .we(wsel[IX_FCCR]), .secure(secure),
      .rev_new(rev_new), .fault_grant(fault_grant),
      .wdata(wdata), .rdata(fccr_rd));

   always_comb begin
      rd_mux = '0;
      if (fp_present) begin
         unique case (1'b1)
            hit[IX_CPAC]: rd_mux = cpac_q;
            hit[IX_NSAC]: rd_mux = secure ? nsac_q : '0;
            hit[IX_FCCR]: rd_mux = fccr_rd;
            hit[IX_FCAR]: rd_mux = fcar_q;
            hit[IX_FDSC]: rd_mux = fdsc_q;
            default:      rd_mux = '0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata   <= '0;
         rd_miss <= 1'b0;
      end else begin
         rd_miss <= rd_en && !listed;
         if (rd_en) rdata <= rd_mux;
      end
   end

   // R2
   absent_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !fp_present) |=> (rdata == '0));

   // R4
   nsac_ns_wi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !secure) |=> $stable(u_nsac.rdata));

   // R12
   miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !listed) |=> (rd_miss && rdata == '0));
endmodule

// File: tb/fpctl_regbank_bench.sv
module fpctl_regbank_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd_en = 1'b0, wr_en = 1'b0;
   logic [11:0] addr = '0;
   logic        secure = 1'b0;
   logic [31:0] wdata = '0;
   logic        fp_present = 1'b1, rev_new = 1'b1, fault_grant = 1'b0;
   logic [31:0] rdata;
   logic        rd_miss;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   always #10 clk = ~clk;

   fpctl_regbank u_fpctl_regbank (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
      .secure(secure), .wdata(wdata), .fp_present(fp_present), .rev_new(rev_new),
      .fault_grant(fault_grant), .rdata(rdata), .rd_miss(rd_miss));

   // reference state, index 1 = Secure copy
   logic [31:0] m_cpac [2];
   logic [31:0] m_fcar [2];
   logic [31:0] m_fdsc [2];
   logic [31:0] m_nsac, m_cs, m_cn;

   task automatic m_reset();
      for (int i = 0; i < 2; i++) begin
         m_cpac[i] = 0; m_fcar[i] = 0; m_fdsc[i] = 0;
      end
      m_nsac = 0; m_cs = 32'hC000_0000; m_cn = 0;
   endtask

   function automatic logic [31:0] m_read(logic [11:0] a, bit s);
      logic [31:0] m;
      if (!fp_present) return 0;
      case (a)
         12'hD88: return m_cpac[s];
         12'hD8C: return s ? m_nsac : 0;
         12'hF38: return m_fcar[s];
         12'hF3C: return m_fdsc[s];
         12'hF34: begin
            if (s) return m_cs;
            m = 32'h5000_0100;
            if (fault_grant) m = m | 32'h0000_0050;
            return (m_cs & m) | m_cn;
         end
         default: return 0;
      endcase
   endfunction

   task automatic m_write(logic [11:0] a, bit s, logic [31:0] d);
      logic [31:0] v;
      if (!fp_present) return;
      case (a)
         12'hD88: m_cpac[s] = d & 32'h00F0_0000;
         12'hD8C: if (s) m_nsac = d & 32'h0000_0C00;
         12'hF38: m_fcar[s] = {d[31:3], 3'b000};
         12'hF3C: m_fdsc[s] = d & 32'h07C0_0000;
         12'hF34: begin
            v = d & 32'hFC00_07FF;
            if (!rev_new) v = v & 32'hC000_017B;
            if (s) m_cs = v;
            else begin
               if (!m_cs[29]) m_cs[30] = v[30];
               if (!m_cs[27]) m_cs[28] = v[28];
               if (fault_grant) begin m_cs[4] = v[4]; m_cs[6] = v[6]; end
               m_cs[8] = v[8];
               m_cn = v & 32'h0000_062B;
            end
         end
         default: ;
      endcase
   endtask

   function automatic string tag_of(logic [11:0] a);
      if (!fp_present) return "R2";
      case (a)
         12'hD88: return "R3";
         12'hD8C: return "R4";
         12'hF34: return "R7";
         12'hF38: return "R5";
         12'hF3C: return "R6";
         default: return "R12";
      endcase
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %08h expected %08h", req, act, exp);
      end
   endtask

   // all tasks start and end on a falling edge
   task automatic wr(logic [11:0] a, bit s, logic [31:0] d);
      addr = a; secure = s; wdata = d; wr_en = 1'b1;
      @(posedge clk);
      m_write(a, s, d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(logic [11:0] a, bit s, string req);
      logic [31:0] e;
      bit listed;
      listed = (a == 12'hD88) || (a == 12'hD8C) || (a == 12'hF34) ||
               (a == 12'hF38) || (a == 12'hF3C);
      addr = a; secure = s; rd_en = 1'b1;
      e = m_read(a, s);
      @(negedge clk);
      rd_en = 1'b0;
      check(req, rdata, e);
      check(listed ? req : "R12", {31'd0, rd_miss}, {31'd0, !listed});
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles == 150000) begin
         fails++;
         $display("FAIL R12 watchdog: actual %0d cycles expected below %0d", cycles, 150000);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [11:0] offs [6];
      int unsigned junk;
      offs[0] = 12'hD88; offs[1] = 12'hD8C; offs[2] = 12'hF34;
      offs[3] = 12'hF38; offs[4] = 12'hF3C; offs[5] = 12'hF30;
      junk = $urandom(32'd2024);
      m_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      check("R1", m_read(12'hF34, 1'b1), 32'hC000_0000);
      rd(12'hF34, 1'b1, "R1");
      rd(12'hF34, 1'b0, "R1");
      rd(12'hD88, 1'b1, "R1");
      rd(12'hF38, 1'b0, "R1");
      rd(12'hD8C, 1'b1, "R1");

      // R3 banking and mask
      wr(12'hD88, 1'b1, 32'hFFFF_FFFF);
      rd(12'hD88, 1'b1, "R3");
      rd(12'hD88, 1'b0, "R3");
      // R4 single copy, NS blocked
      wr(12'hD8C, 1'b1, 32'hFFFF_FFFF);
      wr(12'hD8C, 1'b0, 32'h0000_0000);
      rd(12'hD8C, 1'b0, "R4");
      rd(12'hD8C, 1'b1, "R4");
      // R5, R6
      wr(12'hF38, 1'b0, 32'h1234_567F);
      rd(12'hF38, 1'b0, "R5");
      rd(12'hF38, 1'b1, "R5");
      wr(12'hF3C, 1'b1, 32'hFFFF_FFFF);
      rd(12'hF3C, 1'b1, "R6");

      // R8 lock bits: Secure sets locks with enables cleared
      wr(12'hF34, 1'b1, 32'h2800_0000);
      wr(12'hF34, 1'b0, 32'h5000_0000);
      rd(12'hF34, 1'b1, "R8");
      wr(12'hF34, 1'b1, 32'h0000_0000);
      wr(12'hF34, 1'b0, 32'h5000_0000);
      rd(12'hF34, 1'b1, "R8");
      // R9 grant and monitor-ready
      fault_grant = 1'b0;
      wr(12'hF34, 1'b0, 32'h0000_0150);
      rd(12'hF34, 1'b1, "R9");
      fault_grant = 1'b1;
      wr(12'hF34, 1'b0, 32'h0000_0150);
      rd(12'hF34, 1'b1, "R9");
      rd(12'hF34, 1'b0, "R7");
      // R10 banked bits into NS copy
      wr(12'hF34, 1'b0, 32'hFFFF_FFFF);
      rd(12'hF34, 1'b0, "R10");
      rd(12'hF34, 1'b1, "R10");
      // R11 older revision and reserved bits
      rev_new = 1'b0;
      wr(12'hF34, 1'b1, 32'hFFFF_FFFF);
      rd(12'hF34, 1'b1, "R11");
      rev_new = 1'b1;
      wr(12'hF34, 1'b1, 32'hFFFF_FFFF);
      rd(12'hF34, 1'b1, "R11");
      // R2 absent unit: reads zero, writes ignored
      fp_present = 1'b0;
      wr(12'hF3C, 1'b1, 32'h0000_0000);
      rd(12'hF3C, 1'b1, "R2");
      fp_present = 1'b1;
      rd(12'hF3C, 1'b1, "R2");
      // R12 unlisted
      rd(12'hF40, 1'b1, "R12");
      rd(12'h000, 1'b0, "R12");

      // random mix
      for (int n = 0; n < 600; n++) begin
         fp_present  = ($urandom % 8) != 0;
         rev_new     = $urandom % 2;
         fault_grant = $urandom % 2;
         wr(offs[$urandom % 6], $urandom % 2, $urandom);
         begin
            logic [11:0] a;
            a = offs[$urandom % 6];
            rd(a, $urandom % 2, tag_of(a));
         end
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule